// File: doc/BRIEF.md
# Linked-List Power Sequencer

This block walks small scripts held in a 64-row instruction store and turns them into a timed stream of 16-bit resource-control messages. Each row holds four bytes: the message high byte, the message low byte, a wait count, and the index of the row that follows. A row whose link is 0x3f, or any value above it, is the last row of its script. After each message the engine waits the programmed number of slow-clock ticks before it fetches the linked row.

Four trigger inputs start a script: sleep entry, wakeup of processor groups 1 and 2, wakeup of group 3, and warm reset. Each trigger has its own start-row register. A host programs the store and the registers through a byte-wide write port. The address register is loaded first and the data register second. Every register except the key register stays write-protected until two key bytes arrive in the right order. Three per-group event registers choose level or edge wakeup, allow warm reset, and let software request a power-off.

Top module: `pwr_seq_engine`

## Requirements
- R1: After reset, busy, msg_valid and lock_err are low and the block is locked. All four start registers hold 0x3f, so a trigger that arrives before any configuration produces no message.
- R2: A write of value B to select 1 sets the byte address to B. A following write of value D to select 2 stores D at that byte. Byte 4n+0 is the high message byte of row n, 4n+1 the low byte, 4n+2 the wait count and 4n+3 the link.
- R3: Each row that runs drives {high,low} on msg_data with msg_valid high for exactly one cycle. Rows follow their links. The script ends after the row whose link is 0x3f or more, and busy stays high from the first strobe until that row's wait has expired.
- R4: With tick_en held high, the strobe for the linked row comes d+2 cycles after the strobe of a row with wait count d. The count drops only in cycles with tick_en high, so a nonzero wait stalls while tick_en is low.
- R5: The start registers are written through select 3 (sleep), 4 (group-3 wake), 5 (group-1/2 wake) and 6 (warm reset). A start value of 0x3f disables that trigger: it is consumed and produces no message.
- R6: When several triggers are pending, scripts run in the order warm reset, group-1/2 wake, group-3 wake, sleep. There is one idle cycle between scripts, so a queued script's first strobe comes d+3 cycles after the previous script's last strobe.
- R7: A warm-reset trigger is accepted only while bit 4 is set in at least one group event register (selects 7, 8, 9 for groups 1, 2, 3). Otherwise the trigger is dropped.
- R8: When bit 3 of the group-1 event register is set, the group-1/2 wake script repeats for as long as wake12_req stays high. When bit 3 is clear, the script runs once per rising edge. Bit 3 of the group-3 register does the same for wake3_req.
- R9: Writing the group-1 event register (select 7) with bit 0 set queues the sleep script as a power-off request.
- R10: Writing 0xC0 and then 0x0C to select 0 unlocks the block. Any other order does not unlock it, and writing 0 to select 0 relocks it. A locked write to any select other than 0 changes nothing and sets lock_err, which stays set until reset.
- R11: A rising trigger edge that arrives while a script runs is held and served after that script ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_en | input | 1 | One-cycle enable per slow 32 kHz tick, used for waits |
| sleep_req | input | 1 | Sleep-entry trigger |
| wake12_req | input | 1 | Wakeup trigger for groups 1 and 2 |
| wake3_req | input | 1 | Wakeup trigger for group 3 |
| warm_req | input | 1 | Warm-reset trigger |
| host_wr_en | input | 1 | Host write strobe |
| host_sel | input | 4 | Host register select |
| host_wdata | input | 8 | Host write data |
| msg_valid | output | 1 | One-cycle message strobe |
| msg_data | output | 16 | Resource-control message |
| busy | output | 1 | High while a script is being walked |
| lock_err | output | 1 | Sticky flag for a write refused while locked |

## Verification
A trigger edge reaches the pending latch at the next clock edge. The first strobe appears one edge after that. Later strobes are due d+2 cycles apart inside a script and d+3 cycles apart across queued scripts. The bench stamps every strobe with a cycle number taken on the falling edge and compares the intervals against these counts. It never waits for a fixed latency after a trigger. Instead it lets the block go quiet, compares the whole logged message stream with the scripts it loaded, and counts strobes inside fixed windows for the stall and level-wakeup cases.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;
  localparam int SEL_W = 4;
  localparam logic [SEL_W-1:0] REG_KEY      = 4'd0;
  localparam logic [SEL_W-1:0] REG_MADDR    = 4'd1;
  localparam logic [SEL_W-1:0] REG_MDATA    = 4'd2;
  localparam logic [SEL_W-1:0] REG_PTR_BASE = 4'd3;
  localparam logic [SEL_W-1:0] REG_EV_BASE  = 4'd7;

  localparam int NKIND   = 4;
  localparam int NGROUP  = 3;
  localparam int NLANE   = 4;
  localparam int LANE_HI   = 0;
  localparam int LANE_LO   = 1;
  localparam int LANE_DLY  = 2;
  localparam int LANE_NEXT = 3;

  localparam int EV_OFF     = 0;
  localparam int EV_LEVEL   = 3;
  localparam int EV_WARM_EN = 4;

  typedef enum logic [1:0] {
    KIND_SLEEP  = 2'd0,
    KIND_WAKE3  = 2'd1,
    KIND_WAKE12 = 2'd2,
    KIND_WARM   = 2'd3
  } run_kind_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_EMIT = 2'd1,
    ST_WAIT = 2'd2
  } walk_state_t;
endpackage

// File: rtl/seq_host_regs.sv
module seq_host_regs
  import pwr_seq_pkg::*;
#(
  parameter int IDX_W = 6,
  parameter logic [7:0] KEY_A = 8'hC0,
  parameter logic [7:0] KEY_B = 8'h0C
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [SEL_W-1:0]            wr_sel,
  input  logic [7:0]                  wr_data,
  output logic                        mem_we,
  output logic [IDX_W+1:0]            mem_addr,
  output logic [7:0]                  mem_data,
  output logic [NKIND-1:0][IDX_W-1:0] ptrs,
  output logic                        warm_en,
  output logic                        lvl12,
  output logic                        lvl3,
  output logic                        off_pulse,
  output logic                        lock_err
);
  localparam int ADDR_W = IDX_W + 2;
  localparam logic [IDX_W-1:0] END_IDX = {IDX_W{1'b1}};

  logic unlocked_q, unlocked_n, stage_q, stage_n, err_q, err_n;
  logic [ADDR_W-1:0] maddr_q;
  logic key_wr, prot_wr, bad_wr, maddr_en;
  logic [NGROUP-1:0] ev_warm_q, ev_lvl_q;

  assign key_wr   = wr_en && (wr_sel == REG_KEY);
  assign prot_wr  = wr_en && (wr_sel != REG_KEY) && unlocked_q;
  assign bad_wr   = wr_en && (wr_sel != REG_KEY) && !unlocked_q;
  assign maddr_en = prot_wr && (wr_sel == REG_MADDR);

  always_comb begin
    unlocked_n = unlocked_q;
    stage_n    = stage_q;
    err_n      = err_q | bad_wr;
    if (key_wr) begin
      if (wr_data == 8'h00) begin
        unlocked_n = 1'b0;
        stage_n    = 1'b0;
      end else if (!stage_q && wr_data == KEY_A) begin
        stage_n = 1'b1;
      end else if (stage_q && wr_data == KEY_B) begin
        unlocked_n = 1'b1;
        stage_n    = 1'b0;
      end else begin
        stage_n = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unlocked_q <= 1'b0;
      stage_q    <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      unlocked_q <= unlocked_n;
      stage_q    <= stage_n;
      err_q      <= err_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        maddr_q <= '0;
    else if (maddr_en) maddr_q <= wr_data[ADDR_W-1:0];
  end

  for (genvar k = 0; k < NKIND; k++) begin : g_ptr
    logic en;
    assign en = prot_wr && (wr_sel == REG_PTR_BASE + SEL_W'(k));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  ptrs[k] <= END_IDX;
      else if (en) ptrs[k] <= wr_data[IDX_W-1:0];
    end
  end

  for (genvar g = 0; g < NGROUP; g++) begin : g_ev
    logic en;
    assign en = prot_wr && (wr_sel == REG_EV_BASE + SEL_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ev_warm_q[g] <= 1'b0;
        ev_lvl_q[g]  <= 1'b0;
      end else if (en) begin
        ev_warm_q[g] <= wr_data[EV_WARM_EN];
        ev_lvl_q[g]  <= wr_data[EV_LEVEL];
      end
    end
  end

  assign mem_we    = prot_wr && (wr_sel == REG_MDATA);
  assign mem_addr  = maddr_q;
  assign mem_data  = wr_data;
  assign warm_en   = |ev_warm_q;
  assign lvl12     = ev_lvl_q[0];
  assign lvl3      = ev_lvl_q[2];
  assign off_pulse = prot_wr && (wr_sel == REG_EV_BASE) && wr_data[EV_OFF];
  assign lock_err  = err_q;
endmodule

// File: rtl/seq_imem.sv
module seq_imem
  import pwr_seq_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic                  clk,
  input  logic                  wr_en,
  input  logic [IDX_W+1:0]      wr_addr,
  input  logic [7:0]            wr_data,
  input  logic [IDX_W-1:0]      rd_row,
  output logic [NLANE-1:0][7:0] rd_bytes
);
  localparam int ROWS   = 1 << IDX_W;
  localparam int LANE_W = $clog2(NLANE);

  for (genvar l = 0; l < NLANE; l++) begin : g_lane
    logic [7:0] bank [ROWS];
    logic       we;
    assign we = wr_en && (wr_addr[LANE_W-1:0] == LANE_W'(l));
    always_ff @(posedge clk) begin
      if (we) bank[wr_addr[IDX_W+1:LANE_W]] <= wr_data;
    end
    assign rd_bytes[l] = bank[rd_row];
  end
endmodule

// File: rtl/seq_trig.sv
module seq_trig
  import pwr_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NKIND-1:0] req_in,
  input  logic [NKIND-1:0] lvl_mode,
  input  logic [NKIND-1:0] gate,
  input  logic             off_pulse,
  input  logic             take,
  output logic             req_any,
  output run_kind_t        req_kind
);
  logic [NKIND-1:0] prev_q, pend_q, pend_n, eff, set, clr;

  always_comb begin
    set = req_in & ~prev_q & gate & ~lvl_mode;
    set[KIND_SLEEP] = set[KIND_SLEEP] | off_pulse;
    eff = pend_q | (req_in & lvl_mode);
    req_kind = KIND_SLEEP;
    for (int k = 0; k < NKIND; k++) begin
      if (eff[k]) req_kind = run_kind_t'(2'(k));
    end
    clr    = take ? (NKIND'(1) << req_kind) : '0;
    pend_n = (pend_q & ~clr) | set;
  end

  assign req_any = |eff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      pend_q <= '0;
    end else begin
      prev_q <= req_in;
      pend_q <= pend_n;
    end
  end
endmodule

// File: rtl/seq_walker.sv
module seq_walker
  import pwr_seq_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        tick_en,
  input  logic                        req_any,
  input  run_kind_t                   req_kind,
  input  logic [NKIND-1:0][IDX_W-1:0] ptrs,
  input  logic [NLANE-1:0][7:0]       rd_bytes,
  output logic                        take,
  output logic [IDX_W-1:0]            rd_row,
  output logic                        msg_valid,
  output logic [15:0]                 msg_data,
  output logic                        busy
);
  localparam logic [IDX_W-1:0] END_IDX  = {IDX_W{1'b1}};
  localparam logic [7:0]       END_BYTE = 8'(END_IDX);

  walk_state_t      state_q, state_n;
  logic [IDX_W-1:0] idx_q, idx_n, nxt_q, nxt_n;
  logic [7:0]       cnt_q, cnt_n;

  always_comb begin
    state_n = state_q;
    idx_n   = idx_q;
    nxt_n   = nxt_q;
    cnt_n   = cnt_q;
    take    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_any) begin
          take = 1'b1;
          if (ptrs[req_kind] != END_IDX) begin
            idx_n   = ptrs[req_kind];
            state_n = ST_EMIT;
          end
        end
      end
      ST_EMIT: begin
        cnt_n   = rd_bytes[LANE_DLY];
        nxt_n   = (rd_bytes[LANE_NEXT] >= END_BYTE) ? END_IDX
                                                    : rd_bytes[LANE_NEXT][IDX_W-1:0];
        state_n = ST_WAIT;
      end
      ST_WAIT: begin
        if (cnt_q == 8'd0) begin
          if (nxt_q == END_IDX) begin
            state_n = ST_IDLE;
          end else begin
            idx_n   = nxt_q;
            state_n = ST_EMIT;
          end
        end else if (tick_en) begin
          cnt_n = cnt_q - 8'd1;
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      nxt_q   <= END_IDX;
      cnt_q   <= '0;
    end else begin
      state_q <= state_n;
      idx_q   <= idx_n;
      nxt_q   <= nxt_n;
      cnt_q   <= cnt_n;
    end
  end

  assign rd_row    = idx_q;
  assign msg_valid = (state_q == ST_EMIT);
  assign msg_data  = msg_valid ? {rd_bytes[LANE_HI], rd_bytes[LANE_LO]} : 16'h0000;
  assign busy      = (state_q != ST_IDLE);
endmodule

// File: rtl/pwr_seq_engine.sv
module pwr_seq_engine
  import pwr_seq_pkg::*;
#(
  parameter int IDX_W = 6,
  parameter logic [7:0] KEY_A = 8'hC0,
  parameter logic [7:0] KEY_B = 8'h0C
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_en,
  input  logic        sleep_req,
  input  logic        wake12_req,
  input  logic        wake3_req,
  input  logic        warm_req,
  input  logic        host_wr_en,
  input  logic [3:0]  host_sel,
  input  logic [7:0]  host_wdata,
  output logic        msg_valid,
  output logic [15:0] msg_data,
  output logic        busy,
  output logic        lock_err
);
  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  logic                        mem_we, warm_en, lvl12, lvl3, off_pulse, take, req_any;
  logic [IDX_W+1:0]            mem_addr;
  logic [7:0]                  mem_data;
  logic [NKIND-1:0][IDX_W-1:0] ptrs;
  logic [IDX_W-1:0]            rd_row;
  logic [NLANE-1:0][7:0]       rd_bytes;
  logic [NKIND-1:0]            req_in, lvl_mode, gate;
  run_kind_t                   req_kind;

  always_comb begin
    req_in   = '0;
    lvl_mode = '0;
    gate     = '1;
    req_in[KIND_SLEEP]    = sleep_req;
    req_in[KIND_WAKE3]    = wake3_req;
    req_in[KIND_WAKE12]   = wake12_req;
    req_in[KIND_WARM]     = warm_req;
    lvl_mode[KIND_WAKE3]  = lvl3;
    lvl_mode[KIND_WAKE12] = lvl12;
    gate[KIND_WARM]       = warm_en;
  end

  seq_host_regs #(.IDX_W(IDX_W), .KEY_A(KEY_A), .KEY_B(KEY_B)) u_regs (
    .clk(clk), .rst_n(rst_core_n), .wr_en(host_wr_en), .wr_sel(host_sel),
    .wr_data(host_wdata), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_data(mem_data), .ptrs(ptrs), .warm_en(warm_en), .lvl12(lvl12),
    .lvl3(lvl3), .off_pulse(off_pulse), .lock_err(lock_err)
  );

  seq_imem #(.IDX_W(IDX_W)) u_imem (
    .clk(clk), .wr_en(mem_we), .wr_addr(mem_addr), .wr_data(mem_data),
    .rd_row(rd_row), .rd_bytes(rd_bytes)
  );

  seq_trig u_trig (
    .clk(clk), .rst_n(rst_core_n), .req_in(req_in), .lvl_mode(lvl_mode),
    .gate(gate), .off_pulse(off_pulse), .take(take), .req_any(req_any),
    .req_kind(req_kind)
  );

  seq_walker #(.IDX_W(IDX_W)) u_walk (
    .clk(clk), .rst_n(rst_core_n), .tick_en(tick_en), .req_any(req_any),
    .req_kind(req_kind), .ptrs(ptrs), .rd_bytes(rd_bytes), .take(take),
    .rd_row(rd_row), .msg_valid(msg_valid), .msg_data(msg_data), .busy(busy)
  );
endmodule

// File: rtl/pwr_seq_engine_chk.sv
module pwr_seq_engine_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       host_wr_en,
  input logic [3:0] host_sel,
  input logic       msg_valid,
  input logic       busy,
  input logic       lock_err
);
  // R3
  strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |=> !msg_valid);
  // R3
  strobe_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> busy);
  // R4
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> msg_valid);
  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_err |=> lock_err);
  // R10
  err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_err) |-> $past(host_wr_en && host_sel != 4'd0));
endmodule

bind pwr_seq_engine pwr_seq_engine_chk i_chk (
  .clk(clk), .rst_n(rst_n), .host_wr_en(host_wr_en), .host_sel(host_sel),
  .msg_valid(msg_valid), .busy(busy), .lock_err(lock_err)
);

// File: tb/test_pwr_seq_engine.sv
module test_pwr_seq_engine;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, tick_en, sleep_req, wake12_req, wake3_req, warm_req;
  logic        host_wr_en;
  logic [3:0]  host_sel;
  logic [7:0]  host_wdata;
  logic        msg_valid, busy, lock_err;
  logic [15:0] msg_data;

  pwr_seq_engine i_pwr_seq_engine (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .sleep_req(sleep_req),
    .wake12_req(wake12_req), .wake3_req(wake3_req), .warm_req(warm_req),
    .host_wr_en(host_wr_en), .host_sel(host_sel), .host_wdata(host_wdata),
    .msg_valid(msg_valid), .msg_data(msg_data), .busy(busy), .lock_err(lock_err)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int n_log  = 0;
  logic [15:0] log_msg [0:1023];
  int          log_t   [0:1023];

  always @(negedge clk) begin
    cyc++;
    if (rst_n && msg_valid && n_log < 1024) begin
      log_msg[n_log] = msg_data;
      log_t[n_log]   = cyc;
      n_log++;
    end
    if (cyc == 150000) begin
      fails++;
      $display("FAIL all: watchdog expired act=%0d exp=<150000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  int b_next [0:63];
  int exp_row [0:255];
  int exp_gap [0:255];
  bit exp_gc  [0:255];
  int exp_n = 0;
  int base  = 0;

  function automatic logic [15:0] msg_of(int r);
    return {8'(r * 7 + 17), 8'(8'hC3 ^ 8'(r))};
  endfunction

  function automatic int dly_of(int r);
    return r % 4;
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic host_wr(logic [3:0] sel, logic [7:0] data);
    @(negedge clk);
    host_wr_en = 1'b1; host_sel = sel; host_wdata = data;
    @(negedge clk);
    host_wr_en = 1'b0;
  endtask

  task automatic load(int row, int nxt);
    logic [15:0] m;
    m = msg_of(row);
    host_wr(4'd1, 8'(row * 4 + 0)); host_wr(4'd2, m[15:8]);
    host_wr(4'd1, 8'(row * 4 + 1)); host_wr(4'd2, m[7:0]);
    host_wr(4'd1, 8'(row * 4 + 2)); host_wr(4'd2, 8'(dly_of(row)));
    host_wr(4'd1, 8'(row * 4 + 3)); host_wr(4'd2, 8'(nxt));
    b_next[row] = nxt;
  endtask

  // mask bits: 0 sleep, 1 wake3, 2 wake12, 3 warm
  task automatic set_req(logic [3:0] m, logic v);
    if (m[0]) sleep_req  = v;
    if (m[1]) wake3_req  = v;
    if (m[2]) wake12_req = v;
    if (m[3]) warm_req   = v;
  endtask

  task automatic pulse(logic [3:0] m);
    @(negedge clk); set_req(m, 1'b1);
    @(negedge clk); set_req(m, 1'b0);
  endtask

  task automatic wait_quiet();
    int q;
    q = 0;
    for (int i = 0; i < 3000 && q < 4; i++) begin
      @(negedge clk);
      q = busy ? 0 : q + 1;
    end
  endtask

  task automatic add_run(int start, bit chained);
    int r;
    bit first;
    r = start; first = 1'b1;
    while (r != 63) begin
      exp_row[exp_n] = r;
      if (exp_n > 0) begin
        exp_gap[exp_n] = dly_of(exp_row[exp_n-1]) + (first ? 3 : 2);
        exp_gc[exp_n]  = first ? chained : 1'b1;
      end else begin
        exp_gc[exp_n] = 1'b0;
      end
      first = 1'b0;
      exp_n++;
      r = b_next[r];
    end
  endtask

  task automatic compare(string tag);
    int got;
    got = n_log - base;
    chk(got == exp_n, {tag, " count"}, got, exp_n);
    for (int i = 0; i < exp_n && i < got; i++) begin
      chk(log_msg[base+i] == msg_of(exp_row[i]), {tag, " msg"},
          log_msg[base+i], msg_of(exp_row[i]));
      if (exp_gc[i])
        chk(log_t[base+i] - log_t[base+i-1] == exp_gap[i], {tag, " gap"},
            log_t[base+i] - log_t[base+i-1], exp_gap[i]);
    end
    base  = n_log;
    exp_n = 0;
  endtask

  task automatic apply_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    base = n_log;
  endtask

  initial begin
    rst_n = 1'b0; tick_en = 1'b1;
    sleep_req = 1'b0; wake12_req = 1'b0; wake3_req = 1'b0; warm_req = 1'b0;
    host_wr_en = 1'b0; host_sel = '0; host_wdata = '0;
    for (int i = 0; i < 64; i++) b_next[i] = 63;
    apply_reset();

    // R1: reset state and disabled start rows
    chk(busy == 1'b0, "R1 busy", busy, 0);
    chk(msg_valid == 1'b0, "R1 msg_valid", msg_valid, 0);
    chk(lock_err == 1'b0, "R1 lock_err", lock_err, 0);
    pulse(4'b0111);
    wait_quiet();
    compare("R1 no script before config");

    // R10: keys in wrong order leave the block locked
    host_wr(4'd0, 8'h0C);
    host_wr(4'd0, 8'hC0);
    host_wr(4'd3, 8'd0);
    @(negedge clk);
    chk(lock_err == 1'b1, "R10 wrong key order", lock_err, 1);
    pulse(4'b0001);
    wait_quiet();
    compare("R10 locked pointer write ignored");

    apply_reset();
    host_wr(4'd0, 8'hC0);
    host_wr(4'd0, 8'h0C);
    // R2: indirect loading of scripts
    load(0, 1); load(1, 2); load(2, 63);
    load(10, 11); load(11, 63);
    load(20, 63);
    load(30, 31); load(31, 63);
    host_wr(4'd3, 8'd0);
    host_wr(4'd4, 8'd20);
    host_wr(4'd5, 8'd10);
    host_wr(4'd6, 8'd30);
    chk(lock_err == 1'b0, "R10 unlocked writes", lock_err, 0);

    // R3 / R4: each script on its own
    pulse(4'b0001); wait_quiet(); add_run(0, 0);  compare("R3 sleep script");
    pulse(4'b0100); wait_quiet(); add_run(10, 0); compare("R4 wake12 script");
    pulse(4'b0010); wait_quiet(); add_run(20, 0); compare("R2 wake3 script");

    // R5: disabled start row
    host_wr(4'd4, 8'd63);
    pulse(4'b0010); wait_quiet(); compare("R5 disabled trigger");
    host_wr(4'd4, 8'd20);

    // R7: warm reset needs bit 4
    pulse(4'b1000); wait_quiet(); compare("R7 warm ignored");
    host_wr(4'd8, 8'h10);
    pulse(4'b1000); wait_quiet(); add_run(30, 0); compare("R7 warm enabled");

    // R6: priority with all four pending
    pulse(4'b1111); wait_quiet();
    add_run(30, 0); add_run(10, 1); add_run(20, 1); add_run(0, 1);
    compare("R6 priority order");

    // R11: edge held while busy
    pulse(4'b0001);
    repeat (3) @(negedge clk);
    pulse(4'b0010);
    wait_quiet();
    add_run(0, 0); add_run(20, 1);
    compare("R11 queued trigger");

    // R4: stall while tick_en low
    tick_en = 1'b0;
    pulse(4'b0001);
    repeat (40) @(negedge clk);
    chk(n_log - base == 2, "R4 stalled strobes", n_log - base, 2);
    chk(busy == 1'b1, "R4 busy during stall", busy, 1);
    tick_en = 1'b1;
    wait_quiet();
    add_run(0, 0); exp_gc[2] = 1'b0;
    compare("R4 resume after stall");

    // R8: level wakeup repeats while held
    host_wr(4'd7, 8'h08);
    @(negedge clk); wake12_req = 1'b1;
    repeat (40) @(negedge clk);
    wake12_req = 1'b0;
    wait_quiet();
    chk((n_log - base) >= 4 && ((n_log - base) % 2) == 0, "R8 level repeats",
        n_log - base, 4);
    chk(log_msg[base] == msg_of(10), "R8 level first msg", log_msg[base], msg_of(10));
    base = n_log;
    host_wr(4'd7, 8'h00);
    @(negedge clk); wake12_req = 1'b1;
    repeat (40) @(negedge clk);
    wake12_req = 1'b0;
    wait_quiet();
    add_run(10, 0); compare("R8 edge single run");

    // R9: power-off via group-1 bit 0
    host_wr(4'd7, 8'h01);
    wait_quiet(); add_run(0, 0); compare("R9 power-off");

    // R10: relock, then a refused pointer write
    host_wr(4'd0, 8'h00);
    host_wr(4'd4, 8'd10);
    @(negedge clk);
    chk(lock_err == 1'b1, "R10 relock error", lock_err, 1);
    pulse(4'b0010); wait_quiet(); add_run(20, 0); compare("R10 pointer unchanged");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule